// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block assembles 8-bit words that arrive one bit per serial clock edge on a link with no start or stop bits. Bits are shifted into a shift register in least-significant-first order. When a word is complete it moves to a receive data register that software reads through a small register port. Two status flags report whether a word is waiting and whether a word arrived before the previous one was read. Two level-sensitive interrupt requests report these same conditions.

The serial clock can come from the far end on `sclk_in`, which is resynchronised into the system clock domain and edge detected. The block can also generate the clock itself on `sclk_out` as the master, from a fixed divider of the system clock. A generated clock runs without a break while reception is enabled, so back-to-back words stream in. It parks high once reception is switched off or after an overrun.

An overrun freezes the receiver. The word that caused it is discarded and the stored word is kept. A generated clock stops. Nothing more is received until software has cleared both the overrun flag and the data-ready flag.

Top module: `clksync_rx`

## Requirements
- R1: A frame is DATA_W (8) data bits with no start or stop bit. The first bit sampled becomes bit 0 of the received word and the last becomes the most significant bit.
- R2: When a frame completes while the ready flag (STAT, address 1, bit 0) is 0, the frame is loaded into the data register (DATA, address 2) and the ready flag becomes 1.
- R3: `irq_rx` is 1 while the ready flag is 1, the overrun flag is 0 and the interrupt enable (CTRL, address 0, bit 1) is 1. It is 0 when the interrupt enable is 0.
- R4: When a frame completes while the ready flag is already 1, the overrun flag (STAT bit 1) is set, the ready flag stays 1 and the data register keeps its earlier word.
- R5: `irq_err` equals the overrun flag ANDed with the interrupt enable. While it is 1, `irq_rx` is 0.
- R6: After an overrun, no bit is sampled and a generated clock stays high until both the overrun flag and the ready flag are 0. Clearing only one of them is not enough.
- R7: With CTRL bit 2 = 1 (internal clock), `sclk_out` toggles every CLK_DIV system cycles while CTRL bit 0 (enable) is 1 and the receiver is not frozen. Its first move is a fall. Otherwise it is held high.
- R8: With CTRL bit 2 = 0, `sdata_in` is sampled at each rising edge of `sclk_in`, after both signals pass a SYNC_W-stage synchroniser.
- R9: A read of address 2 clears the ready flag. Writing 0 to STAT bit 1 clears the overrun flag, and writing 1 there leaves it unchanged.
- R10: While CTRL bit 0 is 0, clock edges are ignored. Clearing it drops any partly received frame, and the data register keeps its word.
- R11: After reset, CTRL, STAT and DATA read 0, `sclk_out` is 1 and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the far end (external mode) |
| sclk_out | output | 1 | Generated serial clock, high when idle |
| sdata_in | input | 1 | Serial data |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 STAT, 2 DATA |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| irq_rx | output | 1 | Received-word interrupt request |
| irq_err | output | 1 | Overrun interrupt request |

## Verification
The bench builds the block with CLK_DIV = 2, DATA_W = 8 and SYNC_W = 2. The two-cycle half period keeps generated-clock frames short, so back-to-back words and a forced overrun fit in a few hundred cycles. It also leaves the smallest margin between a bit changing on the falling edge and its sampling on the next rise. With the two-stage synchroniser, the bench's four-cycle external clock phases still show whether the data and clock delays stay matched.

// File: rtl/clksync_rx_pkg.sv
`timescale 1ns/1ps
package clksync_rx_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic int_clk;
    logic irq_en;
    logic rx_en;
  } ctrl_t;

  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned STAT_RDY = 0;
  localparam int unsigned STAT_OVR = 1;

  // Counter width that can hold 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Overrun flag after a status write: a 0 clears, a 1 keeps
  function automatic logic ovr_after_write(input logic cur, input logic wbit);
    return cur & wbit;
  endfunction

endpackage

// File: rtl/clksync_rx_clkgen.sv
`timescale 1ns/1ps
module clksync_rx_clkgen
  import clksync_rx_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned SYNC_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_clk,
  input  logic active,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic sclk_out,
  output logic sample,
  output logic sample_bit
);
  localparam int unsigned DIV_W = cnt_width(CLK_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  // External path: clock and data pass matched synchroniser stages
  logic [SYNC_W:0]   clk_pipe;
  logic [SYNC_W-1:0] dat_pipe;
  logic ext_rise, ext_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '1;
      dat_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[SYNC_W-1:0], sclk_in};
      dat_pipe <= {dat_pipe[SYNC_W-2:0], sdata_in};
    end
  end

  assign ext_rise = clk_pipe[SYNC_W-1] & ~clk_pipe[SYNC_W];
  assign ext_bit  = dat_pipe[SYNC_W-1];

  // Internal path: divider toggles the master clock
  logic             running;
  logic [DIV_W-1:0] div_cnt;
  logic             sclk_q;
  logic             div_wrap;
  logic             int_rise;

  assign running  = int_clk & active;
  assign div_wrap = (div_cnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk_q  <= 1'b1;
    end else if (!running) begin
      div_cnt <= '0;
      sclk_q  <= 1'b1;
    end else if (div_wrap) begin
      div_cnt <= '0;
      sclk_q  <= ~sclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign int_rise   = running & div_wrap & ~sclk_q;
  assign sclk_out   = sclk_q;
  assign sample     = int_clk ? int_rise : (active & ext_rise);
  assign sample_bit = int_clk ? sdata_in : ext_bit;

  // R7: the generated clock is parked high one cycle after it stops running
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> sclk_out);

  // R7: while running, the clock level only changes at a divider wrap
  a_r7_steady_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !div_wrap) |=> $stable(sclk_out));

endmodule

// File: rtl/clksync_rx_shifter.sv
`timescale 1ns/1ps
module clksync_rx_shifter
  import clksync_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sample,
  input  logic              sample_bit,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data
);
  localparam int unsigned CNT_W = cnt_width(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              take;

  assign take = active & sample;

  // Least significant bit first: each new bit enters at the top
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic b);
    return {b, cur[DATA_W-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!active) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (take) begin
      shreg   <= shift_in(shreg, sample_bit);
      bit_cnt <= (bit_cnt == BIT_LAST) ? '0 : bit_cnt + 1'b1;
    end
  end

  assign frame_done = take & (bit_cnt == BIT_LAST);
  assign frame_data = shift_in(shreg, sample_bit);

  // R1: a completed frame restarts the bit count
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (bit_cnt == '0));

  // R10: a disabled receiver holds no partial frame
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_cnt == '0 && shreg == '0));

endmodule

// File: rtl/clksync_rx_regs.sv
`timescale 1ns/1ps
module clksync_rx_regs
  import clksync_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  output logic              int_clk,
  output logic              active,
  output logic              irq_rx,
  output logic              irq_err
);
  ctrl_t             ctrl_q;
  logic              rdy_q, ovr_q, halt_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_ctrl, wr_stat, rd_data;
  logic              load_ev, ovr_ev;

  assign wr_ctrl = bus_sel &  bus_we & (bus_addr == REG_CTRL);
  assign wr_stat = bus_sel &  bus_we & (bus_addr == REG_STAT);
  assign rd_data = bus_sel & ~bus_we & (bus_addr == REG_DATA);
  assign load_ev = frame_done & ~rdy_q;
  assign ovr_ev  = frame_done &  rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      halt_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);

      if (load_ev) begin
        data_q <= frame_data;
        rdy_q  <= 1'b1;
      end else if (rd_data) begin
        rdy_q  <= 1'b0;
      end

      if (ovr_ev)       ovr_q <= 1'b1;
      else if (wr_stat) ovr_q <= ovr_after_write(ovr_q, bus_wdata[STAT_OVR]);

      if (ovr_ev)                halt_q <= 1'b1;
      else if (!ovr_q && !rdy_q) halt_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      REG_STAT: begin
        bus_rdata[STAT_RDY] = rdy_q;
        bus_rdata[STAT_OVR] = ovr_q;
      end
      REG_DATA: bus_rdata = data_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign int_clk = ctrl_q.int_clk;
  assign active  = ctrl_q.rx_en & ~halt_q;
  assign irq_rx  = ctrl_q.irq_en & rdy_q & ~ovr_q;
  assign irq_err = ctrl_q.irq_en & ovr_q;

  wire unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

  // R2: a frame landing on an empty register is stored and flagged
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !rdy_q) |=> (rdy_q && data_q == $past(frame_data)));

  // R4: a frame landing on a full register leaves the old word in place
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rdy_q) |=> (ovr_q && rdy_q && data_q == $past(data_q)));

  // R5: the two interrupt requests are never active together
  a_r5_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_err));

  // R6: a frozen receiver completes no frame
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !frame_done);

endmodule

// File: rtl/clksync_rx.sv
`timescale 1ns/1ps
module clksync_rx
  import clksync_rx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned SYNC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sdata_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              int_clk, active;
  logic              sample, sample_bit;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;

  clksync_rx_clkgen #(.CLK_DIV(CLK_DIV), .SYNC_W(SYNC_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_clk    (int_clk),
    .active     (active),
    .sclk_in    (sclk_in),
    .sdata_in   (sdata_in),
    .sclk_out   (sclk_out),
    .sample     (sample),
    .sample_bit (sample_bit)
  );

  clksync_rx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .sample     (sample),
    .sample_bit (sample_bit),
    .frame_done (frame_done),
    .frame_data (frame_data)
  );

  clksync_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .int_clk    (int_clk),
    .active     (active),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err)
  );

  // R7: while the receiver is off in internal mode, the serial clock stays high
  a_r7_off_high: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clk && !active && $past(!active)) |-> sclk_out);

endmodule

// File: tb/tb_clksync_rx.sv
`timescale 1ns/1ps
module tb_clksync_rx;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CLK_DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b1, sdata_in = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic sclk_out, irq_rx, irq_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clksync_rx #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .SYNC_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sdata_in(sdata_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_err(irq_err));

  // {internal clock, irq enable, word}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b0, 8'h3C}, {1'b1, 1'b1, 8'h01},
    {1'b1, 1'b0, 8'h80}, {1'b0, 1'b1, 8'hFF}, {1'b1, 1'b1, 8'h5A}};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ext_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk_in = 1'b0; sdata_in = b[i];
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic int_bits(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk); while (sclk_out !== 1'b0);
      sdata_in = b[i];
      do @(negedge clk); while (sclk_out !== 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lows;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    bus_read(2'd0, rd); check("R11 ctrl", rd, 0);
    bus_read(2'd1, rd); check("R11 stat", rd, 0);
    bus_read(2'd2, rd); check("R11 data", rd, 0);
    check("R11 sclk_out", sclk_out, 1);
    check("R11 irqs", {irq_rx, irq_err}, 0);

    // Vector table: R1 R2 R3 R8 R9 over both clock sources
    foreach (VEC[k]) begin
      logic mode, ie;
      logic [7:0] w;
      {mode, ie, w} = VEC[k];
      bus_write(2'd0, {5'b0, mode, ie, 1'b1});
      if (mode) int_bits(w); else ext_bits(w, 8);
      bus_write(2'd0, {5'b0, mode, ie, 1'b0});
      bus_read(2'd1, rd); check("R2 ready set", rd, 8'h01);
      check("R3 irq_rx", irq_rx, ie);
      bus_read(2'd2, rd); check(mode ? "R1 word internal" : "R8 R1 word external", rd, w);
      bus_read(2'd1, rd); check("R9 read clears ready", rd, 0);
    end

    // R10: partial frame dropped, data register kept, edges ignored when off
    bus_write(2'd0, 8'h03);
    ext_bits(8'hFF, 3);
    bus_write(2'd0, 8'h02);
    bus_read(2'd2, rd); check("R10 data kept", rd, 8'h5A);
    ext_bits(8'h77, 8);
    bus_read(2'd1, rd); check("R10 ignored while off", rd, 0);
    bus_write(2'd0, 8'h03);
    ext_bits(8'h12, 8);
    bus_read(2'd2, rd); check("R10 fresh frame", rd, 8'h12);
    bus_write(2'd0, 8'h00);

    // R4 R5 R6 R7 R9: overrun with the generated clock
    bus_write(2'd0, 8'h07);
    int_bits(8'h33);
    int_bits(8'hCC);
    @(negedge clk);
    bus_read(2'd1, rd); check("R4 both flags", rd, 8'h03);
    check("R5 irq_err", irq_err, 1);
    check("R5 irq_rx off", irq_rx, 0);
    lows = 0;
    repeat (20) begin @(negedge clk); if (sclk_out == 1'b0) lows++; end
    check("R6 R7 clock stopped", lows, 0);
    bus_write(2'd1, 8'h02);
    bus_read(2'd1, rd); check("R9 write 1 keeps overrun", rd, 8'h03);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); check("R9 write 0 clears overrun", rd, 8'h01);
    check("R5 irq after clear", {irq_rx, irq_err}, 2'b10);
    lows = 0;
    repeat (10) begin @(negedge clk); if (sclk_out == 1'b0) lows++; end
    check("R6 still frozen", lows, 0);
    bus_read(2'd2, rd); check("R4 old word kept", rd, 8'h33);
    lows = 0;
    for (int i = 0; i < 20 && sclk_out !== 1'b0; i++) @(negedge clk);
    while (sclk_out === 1'b0) begin lows++; @(negedge clk); end
    check("R7 low phase length", lows, CLK_DIV);
    bus_write(2'd0, 8'h04);
    @(negedge clk);
    check("R7 parked high", sclk_out, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule